// File: doc/BRIEF.md
# Display FIFO Underrun Interrupt Controller

This block watches the output pixel FIFOs of three compositing channels for underflow. Each FIFO is modelled by a one-cycle underflow pulse input. A pulse sets a sticky per-channel flag. The flag sets whether or not that channel's interrupt is enabled. A per-channel enable decides which flags reach a single registered interrupt line.

Software uses a small register port with valid, write, address and data signals. Through it, software sets the enables, clears stale flags by writing ones, masks single channels atomically, and reads a saturating count of underrun events. The expected unmask sequence is: clear the channel's flag first, then set its enable. An underflow that happened while the channel was masked then never raises the interrupt.

Register map: address 0 is the enable register, address 1 the flag register, address 2 the event count and address 3 the mask-clear register. The channel number is also the bit index within a register.

Top module: `fifo_urun_irq_ctrl`

## Requirements
- R1: After reset the enable register, the flag register, the event count and `irq` are all zero.
- R2: An underflow pulse on `urun_pulse[i]` sets bit i of the flag register (address 1) at the next clock edge, whether or not channel i is enabled. The bit then holds until software clears it.
- R3: A write to address 1 clears each flag bit written as one and leaves flag bits written as zero unchanged. One write may clear all three flags.
- R4: When an underflow pulse and a write-one-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R5: `irq` is registered. It is high in the cycle after the AND of flags and enables is nonzero, and low in the cycle after that AND is zero.
- R6: A flag whose channel is disabled never raises `irq`. If software clears that flag before enabling the channel, `irq` stays low.
- R7: Address 0 holds the enable bits in bits [2:0]. A write there replaces all enable bits, and a read returns them with the upper bits zero.
- R8: Writing ones to address 3 clears only the matching enable bits. Enable bits written as zero keep their value, and reads of address 3 return zero.
- R9: In a given cycle, the event count at address 2 rises by the number of enabled channels whose flag goes from 0 to 1. A pulse on a disabled channel does not count, and neither does a pulse on a channel whose flag is already set.
- R10: The event count saturates at all ones and stays there under further events.
- R11: `reg_rdata` is zero whenever no read is presented (`reg_valid` low or `reg_write` high). The count is returned zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| urun_pulse | input | NUM_CH | Per-channel FIFO underflow pulse |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address (0 enable, 1 flags, 2 count, 3 mask-clear) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Combined registered interrupt |

## Verification
Each kind of internal fault shows up at the ports within about one cycle:
- A stuck or lost flag appears on the next read of address 1.
- A wrong enable appears in `irq` one cycle after the flag is set.
- A miscounted event appears as a wrong value at address 2 in the same access.

The bench sweeps every enable mask against every pulse pattern. It keeps a saturating reference count, so a count error shows as a drift at the first affected combination. Stale-flag, same-cycle set/clear and saturation cases then exercise the orderings that the sweep cannot reach.

// File: rtl/urun_pkg.sv
package urun_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      RA_ENABLE  = 2'd0,
      RA_FLAGS   = 2'd1,
      RA_COUNT   = 2'd2,
      RA_MASKCLR = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/urun_flag_bank.sv
module urun_flag_bank #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] urun_i,
   input  logic [NUM_CH-1:0] clr_i,
   input  logic [NUM_CH-1:0] en_i,
   output logic [NUM_CH-1:0] flags_o,
   output logic [NUM_CH-1:0] newset_o
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic st_q;
      always_ff @(posedge clk) begin
         if (rst)            st_q <= 1'b0;
         else if (urun_i[i]) st_q <= 1'b1;
         else if (clr_i[i])  st_q <= 1'b0;
      end
      assign flags_o[i]  = st_q;
      assign newset_o[i] = urun_i[i] & ~st_q & en_i[i];

      // R2
      flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
         st_q && !clr_i[i] |=> st_q);
      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
         urun_i[i] |=> st_q);
      // R3
      flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
         clr_i[i] && !urun_i[i] |=> !st_q);
   end
endmodule

// File: rtl/urun_sat_counter.sv
module urun_sat_counter #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] event_i,
   output logic [CNT_W-1:0]  count_o
);
   localparam int INC_W = $clog2(NUM_CH + 1);
   localparam int SUM_W = CNT_W + 1;

   if (SUM_W < INC_W) begin : g_bad_width
      $error("CNT_W too small for NUM_CH");
   end

   logic [INC_W-1:0] part [NUM_CH+1];
   assign part[0] = '0;
   for (genvar i = 0; i < NUM_CH; i++) begin : g_pop
      assign part[i+1] = part[i] + INC_W'(event_i[i]);
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum;
   assign sum = {1'b0, cnt_q} + SUM_W'(part[NUM_CH]);

   always_ff @(posedge clk) begin
      if (rst)             cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= '1;
      else                 cnt_q <= sum[CNT_W-1:0];
   end
   assign count_o = cnt_q;

   // R10
   cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      &cnt_q |=> &cnt_q);
   // R9
   cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
      event_i == '0 |=> cnt_q == $past(cnt_q));
   // R9
   cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
      event_i != '0 |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/urun_ctrl_regs.sv
module urun_ctrl_regs
   import urun_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  reg_addr_e         addr_i,
   input  logic [NUM_CH-1:0] wbits_i,
   output logic [NUM_CH-1:0] en_o,
   output logic [NUM_CH-1:0] flag_clr_o
);
   logic [NUM_CH-1:0] en_q;
   logic wr_en, wr_mclr;

   assign wr_en      = wr_i && addr_i == RA_ENABLE;
   assign wr_mclr    = wr_i && addr_i == RA_MASKCLR;
   assign flag_clr_o = (wr_i && addr_i == RA_FLAGS) ? wbits_i : '0;

   always_ff @(posedge clk) begin
      if (rst)          en_q <= '0;
      else if (wr_en)   en_q <= wbits_i;
      else if (wr_mclr) en_q <= en_q & ~wbits_i;
   end
   assign en_o = en_q;

   // R8
   mclr_target_chk: assert property (@(posedge clk) disable iff (rst)
      wr_mclr |=> (en_q & $past(wbits_i)) == '0);
   // R8
   mclr_others_chk: assert property (@(posedge clk) disable iff (rst)
      wr_mclr |=> (en_q | $past(wbits_i)) == ($past(en_q) | $past(wbits_i)));
   // R7
   en_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en && !wr_mclr |=> $stable(en_q));
endmodule

// File: rtl/fifo_urun_irq_ctrl.sv
module fifo_urun_irq_ctrl
   import urun_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] urun_pulse,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   if (NUM_CH > DATA_W || CNT_W > DATA_W || NUM_CH < 1) begin : g_bad_cfg
      $error("NUM_CH and CNT_W must fit in DATA_W");
   end

   logic [NUM_CH-1:0] en, flags, clr, newset;
   logic [CNT_W-1:0]  count;
   logic              wr, rd, irq_q;
   reg_addr_e         addr;
   logic              wdata_unused;

   assign wr   = reg_valid & reg_write;
   assign rd   = reg_valid & ~reg_write;
   assign addr = reg_addr_e'(reg_addr);
   assign wdata_unused = ^reg_wdata;

   urun_ctrl_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk(clk), .rst(rst), .wr_i(wr), .addr_i(addr),
      .wbits_i(reg_wdata[NUM_CH-1:0]), .en_o(en), .flag_clr_o(clr));

   urun_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
      .clk(clk), .rst(rst), .urun_i(urun_pulse), .clr_i(clr),
      .en_i(en), .flags_o(flags), .newset_o(newset));

   urun_sat_counter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .event_i(newset), .count_o(count));

   always_comb begin
      reg_rdata = '0;
      if (rd) begin
         unique case (addr)
            RA_ENABLE:  reg_rdata = DATA_W'(en);
            RA_FLAGS:   reg_rdata = DATA_W'(flags);
            RA_COUNT:   reg_rdata = DATA_W'(count);
            RA_MASKCLR: reg_rdata = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |(flags & en);
   end
   assign irq = irq_q;

   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      |(flags & en) |=> irq);
   // R6
   irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (flags & en) == '0 |=> !irq);
   // R11
   rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !rd |-> reg_rdata == '0);
endmodule

// File: tb/tb_fifo_urun_irq_ctrl.sv
`timescale 1ns/100ps
module tb_fifo_urun_irq_ctrl;
   localparam int NCH = 3;
   localparam int CW  = 6;
   localparam int DW  = 32;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 0, rst = 1;
   logic [NCH-1:0] urun_pulse = '0;
   logic reg_valid = 0, reg_write = 0;
   logic [1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic irq;

   int n_chk = 0, n_bad = 0, exp_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fifo_urun_irq_ctrl #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(DW)) dut (
      .clk(clk), .rst(rst), .urun_pulse(urun_pulse), .reg_valid(reg_valid),
      .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   task automatic chk(input string req, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 0; reg_write = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_valid = 1; reg_write = 0; reg_addr = a;
      #1 d = reg_rdata;
      reg_valid = 0;
   endtask

   task automatic pulse(input logic [NCH-1:0] p);
      @(negedge clk);
      urun_pulse = p;
      @(negedge clk);
      urun_pulse = '0;
   endtask

   function automatic int pop(input logic [NCH-1:0] v);
      int c = 0;
      for (int i = 0; i < NCH; i++) c += v[i];
      return c;
   endfunction

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1 reset state
      chk("R1 irq", irq, 0);
      rd(0, d); chk("R1 enable", d, 0);
      rd(1, d); chk("R1 flags", d, 0);
      rd(2, d); chk("R1 count", d, 0);
      // R11 no read presented
      #1 chk("R11 idle rdata", reg_rdata, 0);

      // Sweep: every enable mask x every pulse pattern
      for (int m = 0; m < 8; m++) begin
         for (int p = 1; p < 8; p++) begin
            wr(0, 0);
            wr(1, 7);
            wr(0, m);
            pulse(p[NCH-1:0]);
            exp_cnt = sat(exp_cnt + pop(p[NCH-1:0] & m[NCH-1:0]));
            @(negedge clk);
            chk("R5/R6 irq", irq, (p & m) != 0);
            rd(1, d); chk("R2 flags", d, p);
            rd(2, d); chk("R9 count", d, exp_cnt);
            rd(0, d); chk("R7 enable", d, m);
         end
      end
      wr(0, 0); wr(1, 7);

      // R2 sticky across time, R3 partial and full clear
      pulse(3'b101);
      repeat (4) @(negedge clk);
      rd(1, d); chk("R2 sticky", d, 3'b101);
      wr(1, 3'b001);
      rd(1, d); chk("R3 partial clear", d, 3'b100);
      pulse(3'b011);
      wr(1, 3'b111);
      rd(1, d); chk("R3 clear all", d, 0);

      // R4 set wins over clear, same cycle; R9 no count on already set flag
      wr(0, 3'b001);
      pulse(3'b001);
      exp_cnt = sat(exp_cnt + 1);
      @(negedge clk);
      reg_valid = 1; reg_write = 1; reg_addr = 1; reg_wdata = 3'b011;
      urun_pulse = 3'b011;
      @(negedge clk);
      reg_valid = 0; reg_write = 0; urun_pulse = 0;
      rd(1, d); chk("R4 set wins", d, 3'b011);
      rd(2, d); chk("R9 already-set not counted", d, exp_cnt);

      // R6 stale flag cleared before unmask
      wr(0, 0); wr(1, 7);
      pulse(3'b100);
      @(negedge clk);
      chk("R6 masked irq", irq, 0);
      wr(1, 3'b100);
      wr(0, 3'b100);
      repeat (2) @(negedge clk);
      chk("R6 stale no irq", irq, 0);
      rd(2, d); chk("R9 masked not counted", d, exp_cnt);

      // R5 irq falls one cycle after clear
      pulse(3'b100);
      exp_cnt = sat(exp_cnt + 1);
      @(negedge clk);
      chk("R5 irq high", irq, 1);
      wr(1, 3'b100);
      chk("R5 irq still high", irq, 1);
      @(negedge clk);
      chk("R5 irq low", irq, 0);

      // R8 mask-clear
      wr(0, 3'b111);
      wr(3, 3'b010);
      rd(0, d); chk("R8 mask one", d, 3'b101);
      rd(3, d); chk("R8 read zero", d, 0);
      wr(3, 3'b000);
      rd(0, d); chk("R8 zero keeps", d, 3'b101);

      // R10 saturation
      wr(0, 3'b111);
      for (int k = 0; k < 25; k++) begin
         wr(1, 7);
         pulse(3'b111);
         exp_cnt = sat(exp_cnt + 3);
      end
      rd(2, d); chk("R10 saturated", d, CMAX);
      wr(1, 7); pulse(3'b010);
      rd(2, d); chk("R10 holds", d, CMAX);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule